// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Tag Wakeup

This block holds renamed instructions until their operands are available, then sends them to the functional units out of program order. Each of the `Q` slots keeps two source tags, each with an available flag, and one destination tag. Every slot runs a small state machine. Its states are FREE, WAIT and READY. The transitions are:

- FREE to WAIT (load-pending): a slot is written while at least one source is still missing.
- FREE to READY (load-ready): a slot is written with both sources already available, either flagged at dispatch or woken in that same cycle.
- WAIT to READY (wake): the last missing source sees its producer's tag on the broadcast bus.
- READY to FREE (issue): the select logic grants the slot.

Up to `D` instructions arrive per cycle on the dispatch lanes. They are taken all together or not at all. Execution units announce finished results on `NBC` broadcast ports. A source wakes only on its own producer's tag. A later writer of the same architectural register carries a different physical tag, so its broadcast cannot release a reader that needs the older value.

The select logic looks at every slot and grants up to `F` ready slots per cycle. The oldest slot always wins. Age is kept in a matrix of pairwise "older than" bits, so priority does not depend on where a slot sits in the array. Granted instructions appear on the issue ports in the same cycle, and their slots are freed at the next clock edge.

Top module: `issue_queue`

## Requirements
- R1: After reset every slot is free, `iss_valid` is all zero, and `disp_ok` is 1 while no dispatch lane is valid.
- R2: `disp_ok` is 1 exactly when the number of free slots is at least the number of valid dispatch lanes. When it is 0, no lane is written, and the refused instructions never issue.
- R3: A source whose available flag is 1 at dispatch counts as ready. An instruction with both sources available issues in the cycle after its dispatch.
- R4: A valid broadcast on any port whose tag equals a waiting source marks that source ready at the clock edge. The instruction issues in the cycle after its last missing source is woken. Two sources may be woken in one cycle by two ports.
- R5: A broadcast whose tag differs from a source's producer tag, or whose valid bit is 0, leaves that source waiting.
- R6: A broadcast in the same cycle as the dispatch of a matching source wakes that source. The instruction then issues in the next cycle.
- R7: A waiting older instruction does not hold back a younger ready instruction.
- R8: Among ready instructions, the oldest in dispatch order issue first, at most `F` per cycle. Within one dispatch cycle, a lower lane number counts as older. Age does not depend on slot position.
- R9: A slot granted in one cycle is free at the next edge and can take a new instruction.
- R10: Issue slots are filled from slot 0 upward. Slot 0 carries the oldest granted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | D | Per-lane dispatch request |
| disp_src1 | input | D*TAG_W | First source producer tag per lane |
| disp_src1_rdy | input | D | First source already available |
| disp_src2 | input | D*TAG_W | Second source producer tag per lane |
| disp_src2_rdy | input | D | Second source already available |
| disp_dst | input | D*TAG_W | Destination tag per lane |
| disp_ok | output | 1 | Dispatch group accepted this cycle |
| bc_valid | input | NBC | Broadcast port valid |
| bc_tag | input | NBC*TAG_W | Broadcast destination tags |
| iss_valid | output | F | Issue slot carries an instruction |
| iss_dst | output | F*TAG_W | Destination tag of each issued instruction |

## Verification
The hardest case to reach is an age order that disagrees with slot order. Instructions have to be issued out of the lowest slots so that younger instructions are placed there while older ones still wait higher up. The stimulus first parks two pairs of instructions on different tags. It then releases the lower pair, refills those slots, and finally wakes all four together. A second sequence fills seven slots, shows that a two-lane request is refused while a single lane is accepted, and drains the full queue to observe the oldest-first order at the issue width limit.

// File: rtl/iq_pkg.sv
package iq_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;

endpackage

// File: rtl/iq_entry.sv
module iq_entry
    import iq_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int NBC   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [TAG_W-1:0]     wr_src1,
    input  logic                 wr_rdy1,
    input  logic [TAG_W-1:0]     wr_src2,
    input  logic                 wr_rdy2,
    input  logic [TAG_W-1:0]     wr_dst,
    input  logic [NBC-1:0]       bc_valid,
    input  logic [NBC*TAG_W-1:0] bc_tag,
    input  logic                 grant,
    output logic                 occupied,
    output logic                 ready,
    output logic [TAG_W-1:0]     dst
);

    slot_state_e      state_q, state_d;
    logic [TAG_W-1:0] src1_q, src1_d, src2_q, src2_d, dst_q, dst_d;
    logic             rdy1_q, rdy1_d, rdy2_q, rdy2_d;

    function automatic logic tag_hit(input logic [TAG_W-1:0]     t,
                                     input logic [NBC-1:0]       v,
                                     input logic [NBC*TAG_W-1:0] tags);
        logic hit;
        hit = 1'b0;
        for (int b = 0; b < NBC; b++) begin
            if (v[b] && (tags[b*TAG_W +: TAG_W] == t)) hit = 1'b1;
        end
        return hit;
    endfunction

    // next-state and field update
    always_comb begin
        state_d = state_q;
        src1_d  = src1_q;
        src2_d  = src2_q;
        dst_d   = dst_q;
        rdy1_d  = rdy1_q;
        rdy2_d  = rdy2_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (wr_en) begin
                    src1_d  = wr_src1;
                    src2_d  = wr_src2;
                    dst_d   = wr_dst;
                    rdy1_d  = wr_rdy1 | tag_hit(wr_src1, bc_valid, bc_tag);
                    rdy2_d  = wr_rdy2 | tag_hit(wr_src2, bc_valid, bc_tag);
                    state_d = (rdy1_d && rdy2_d) ? SLOT_READY : SLOT_WAIT;
                end
            end
            SLOT_WAIT: begin
                rdy1_d = rdy1_q | tag_hit(src1_q, bc_valid, bc_tag);
                rdy2_d = rdy2_q | tag_hit(src2_q, bc_valid, bc_tag);
                if (rdy1_d && rdy2_d) state_d = SLOT_READY;
            end
            SLOT_READY: begin
                if (grant) state_d = SLOT_FREE;
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
            src1_q  <= '0;
            src2_q  <= '0;
            dst_q   <= '0;
            rdy1_q  <= 1'b0;
            rdy2_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            src1_q  <= src1_d;
            src2_q  <= src2_d;
            dst_q   <= dst_d;
            rdy1_q  <= rdy1_d;
            rdy2_q  <= rdy2_d;
        end
    end

    // outputs
    always_comb begin
        occupied = (state_q != SLOT_FREE);
        ready    = (state_q == SLOT_READY);
        dst      = dst_q;
    end

endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
    parameter int Q = 8,
    parameter int D = 2
) (
    input  logic [Q-1:0]   free_vec,
    input  logic [D-1:0]   req,
    output logic [D*Q-1:0] sel,
    output logic           accept
);

    localparam int CW = $clog2(Q + 1);

    logic [Q-1:0]   taken;
    logic [D*Q-1:0] raw_sel;
    logic [CW-1:0]  nfree, nreq;
    logic           found;

    always_comb begin
        taken   = '0;
        raw_sel = '0;
        nfree   = '0;
        nreq    = '0;
        found   = 1'b0;
        for (int i = 0; i < Q; i++) begin
            nfree = nfree + {{(CW-1){1'b0}}, free_vec[i]};
        end
        for (int k = 0; k < D; k++) begin
            nreq  = nreq + {{(CW-1){1'b0}}, req[k]};
            found = 1'b0;
            for (int i = 0; i < Q; i++) begin
                if (req[k] && !found && free_vec[i] && !taken[i]) begin
                    raw_sel[k*Q + i] = 1'b1;
                    taken[i]         = 1'b1;
                    found            = 1'b1;
                end
            end
        end
        accept = (nfree >= nreq);
        sel    = accept ? raw_sel : '0;
    end

endmodule

// File: rtl/iq_age.sv
module iq_age #(
    parameter int Q = 8,
    parameter int D = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [Q-1:0]   occ,
    input  logic [D*Q-1:0] sel,
    output logic [Q*Q-1:0] older
);

    logic [Q*Q-1:0] older_q, older_d;

    // older[j*Q+i] = 1 means slot j holds an instruction older than slot i
    always_comb begin
        older_d = older_q;
        for (int k = 0; k < D; k++) begin
            for (int e = 0; e < Q; e++) begin
                if (sel[k*Q + e]) begin
                    for (int j = 0; j < Q; j++) begin
                        older_d[e*Q + j] = 1'b0;
                        older_d[j*Q + e] = occ[j];
                    end
                    for (int m = 0; m < k; m++) begin
                        for (int j = 0; j < Q; j++) begin
                            if (sel[m*Q + j]) older_d[j*Q + e] = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) older_q <= '0;
        else        older_q <= older_d;
    end

    assign older = older_q;

endmodule

// File: rtl/iq_select.sv
module iq_select #(
    parameter int Q = 8,
    parameter int F = 2
) (
    input  logic [Q-1:0]   ready_vec,
    input  logic [Q*Q-1:0] older,
    output logic [F*Q-1:0] gnt,
    output logic [Q-1:0]   gnt_any
);

    logic [Q-1:0] pend;
    logic [Q-1:0] row;
    logic         win;

    always_comb begin
        pend    = ready_vec;
        gnt     = '0;
        gnt_any = '0;
        row     = '0;
        win     = 1'b0;
        for (int r = 0; r < F; r++) begin
            for (int i = 0; i < Q; i++) begin
                win = pend[i];
                for (int j = 0; j < Q; j++) begin
                    if (pend[j] && older[j*Q + i]) win = 1'b0;
                end
                row[i] = win;
            end
            gnt[r*Q +: Q] = row;
            gnt_any       = gnt_any | row;
            pend          = pend & ~row;
        end
    end

endmodule

// File: rtl/issue_queue.sv
module issue_queue #(
    parameter int Q     = 8,
    parameter int F     = 2,
    parameter int D     = 2,
    parameter int NBC   = 2,
    parameter int TAG_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [D-1:0]         disp_valid,
    input  logic [D*TAG_W-1:0]   disp_src1,
    input  logic [D-1:0]         disp_src1_rdy,
    input  logic [D*TAG_W-1:0]   disp_src2,
    input  logic [D-1:0]         disp_src2_rdy,
    input  logic [D*TAG_W-1:0]   disp_dst,
    output logic                 disp_ok,
    input  logic [NBC-1:0]       bc_valid,
    input  logic [NBC*TAG_W-1:0] bc_tag,
    output logic [F-1:0]         iss_valid,
    output logic [F*TAG_W-1:0]   iss_dst
);

    logic [Q-1:0]       occ_vec;
    logic [Q-1:0]       ready_vec;
    logic [Q-1:0]       free_vec;
    logic [D*Q-1:0]     lane_sel;
    logic [Q*Q-1:0]     older;
    logic [F*Q-1:0]     gnt;
    logic [Q-1:0]       gnt_any;
    logic [Q*TAG_W-1:0] ent_dst;

    assign free_vec = ~occ_vec;

    iq_alloc #(.Q(Q), .D(D)) u_alloc (
        .free_vec (free_vec),
        .req      (disp_valid),
        .sel      (lane_sel),
        .accept   (disp_ok)
    );

    iq_age #(.Q(Q), .D(D)) u_age (
        .clk   (clk),
        .rst_n (rst_n),
        .occ   (occ_vec),
        .sel   (lane_sel),
        .older (older)
    );

    iq_select #(.Q(Q), .F(F)) u_select (
        .ready_vec (ready_vec),
        .older     (older),
        .gnt       (gnt),
        .gnt_any   (gnt_any)
    );

    for (genvar i = 0; i < Q; i++) begin : g_slot
        logic             wr;
        logic [TAG_W-1:0] s1, s2, dd;
        logic             r1, r2;

        always_comb begin
            wr = 1'b0;
            s1 = '0;
            s2 = '0;
            dd = '0;
            r1 = 1'b0;
            r2 = 1'b0;
            for (int k = 0; k < D; k++) begin
                if (lane_sel[k*Q + i]) begin
                    wr = 1'b1;
                    s1 = disp_src1[k*TAG_W +: TAG_W];
                    s2 = disp_src2[k*TAG_W +: TAG_W];
                    dd = disp_dst[k*TAG_W +: TAG_W];
                    r1 = disp_src1_rdy[k];
                    r2 = disp_src2_rdy[k];
                end
            end
        end

        iq_entry #(.TAG_W(TAG_W), .NBC(NBC)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr),
            .wr_src1  (s1),
            .wr_rdy1  (r1),
            .wr_src2  (s2),
            .wr_rdy2  (r2),
            .wr_dst   (dd),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .grant    (gnt_any[i]),
            .occupied (occ_vec[i]),
            .ready    (ready_vec[i]),
            .dst      (ent_dst[i*TAG_W +: TAG_W])
        );
    end

    // issue port mux
    always_comb begin
        iss_valid = '0;
        iss_dst   = '0;
        for (int r = 0; r < F; r++) begin
            for (int i = 0; i < Q; i++) begin
                if (gnt[r*Q + i]) begin
                    iss_valid[r]             = 1'b1;
                    iss_dst[r*TAG_W +: TAG_W] = ent_dst[i*TAG_W +: TAG_W];
                end
            end
        end
    end

endmodule

// File: rtl/issue_queue_chk.sv
module issue_queue_chk #(
    parameter int Q = 8,
    parameter int F = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [Q-1:0]   occ_vec,
    input logic [Q-1:0]   ready_vec,
    input logic [Q-1:0]   gnt_any,
    input logic [Q*Q-1:0] older,
    input logic [F-1:0]   iss_valid,
    input logic           disp_ok
);

    logic age_viol;

    always_comb begin
        age_viol = 1'b0;
        for (int i = 0; i < Q; i++) begin
            for (int j = 0; j < Q; j++) begin
                if (gnt_any[i] && ready_vec[j] && !gnt_any[j] && older[j*Q + i])
                    age_viol = 1'b1;
            end
        end
    end

    // R8: no ready instruction is skipped in favour of a younger one
    a_r8_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
        !age_viol);

    // R4: only slots whose sources are all available are granted
    a_r4_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any & ~ready_vec) == '0);

    // R8: issued count matches granted slots
    a_r8_grant_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt_any) == $countones(iss_valid));

    // R2: a refused cycle never raises occupancy
    a_r2_refuse_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_ok |=> $countones(occ_vec) <= $past($countones(occ_vec)));

    for (genvar i = 0; i < Q; i++) begin : g_free
        // R9: a granted slot is empty after the edge
        a_r9_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_any[i] |=> !occ_vec[i]);
    end

    for (genvar r = 0; r + 1 < F; r++) begin : g_pack
        // R10: issue slots are packed from slot 0
        a_r10_slot_packed: assert property (@(posedge clk) disable iff (!rst_n)
            !iss_valid[r] |-> !iss_valid[r+1]);
    end

endmodule

bind issue_queue issue_queue_chk #(.Q(Q), .F(F)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .occ_vec   (occ_vec),
    .ready_vec (ready_vec),
    .gnt_any   (gnt_any),
    .older     (older),
    .iss_valid (iss_valid),
    .disp_ok   (disp_ok)
);

// File: tb/issue_queue_test.sv
module issue_queue_test;

    localparam int Q  = 8;
    localparam int F  = 2;
    localparam int D  = 2;
    localparam int NB = 2;
    localparam int TW = 6;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [D-1:0]    disp_valid;
    logic [D*TW-1:0] disp_src1, disp_src2, disp_dst;
    logic [D-1:0]    disp_src1_rdy, disp_src2_rdy;
    logic            disp_ok;
    logic [NB-1:0]   bc_valid;
    logic [NB*TW-1:0] bc_tag;
    logic [F-1:0]    iss_valid;
    logic [F*TW-1:0] iss_dst;

    always #5 clk = ~clk;

    issue_queue #(.Q(Q), .F(F), .D(D), .NBC(NB), .TAG_W(TW)) uut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_src1(disp_src1), .disp_src1_rdy(disp_src1_rdy),
        .disp_src2(disp_src2), .disp_src2_rdy(disp_src2_rdy), .disp_dst(disp_dst),
        .disp_ok(disp_ok), .bc_valid(bc_valid), .bc_tag(bc_tag),
        .iss_valid(iss_valid), .iss_dst(iss_dst)
    );

    typedef struct {
        int    cyc;
        int    slot;
        int    dst;
        string req;
    } exp_t;

    exp_t sb[$];
    exp_t mon_e;
    int   errors = 0;
    int   checks = 0;
    int   cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic clr();
        disp_valid = '0; disp_src1 = '0; disp_src2 = '0; disp_dst = '0;
        disp_src1_rdy = '0; disp_src2_rdy = '0;
        bc_valid = '0; bc_tag = '0;
    endtask

    task automatic tick();
        @(posedge clk); #1; clr();
    endtask

    task automatic put(int lane, int s1, bit r1, int s2, bit r2, int dst);
        disp_valid[lane]            = 1'b1;
        disp_src1[lane*TW +: TW]    = TW'(s1);
        disp_src1_rdy[lane]         = r1;
        disp_src2[lane*TW +: TW]    = TW'(s2);
        disp_src2_rdy[lane]         = r2;
        disp_dst[lane*TW +: TW]     = TW'(dst);
    endtask

    task automatic bcast(int port, int tag);
        bc_valid[port]          = 1'b1;
        bc_tag[port*TW +: TW]   = TW'(tag);
    endtask

    task automatic expect_iss(int at, int slot, int dst, string req);
        exp_t e;
        e.cyc = at; e.slot = slot; e.dst = dst; e.req = req;
        sb.push_back(e);
    endtask

    task automatic check_ok(bit exp, string req);
        #1;
        checks++;
        if (disp_ok !== exp) begin
            errors++;
            $display("FAIL %s: disp_ok actual %0b expected %0b", req, disp_ok, exp);
        end
    endtask

    task automatic check_idle(string req);
        @(negedge clk);
        checks++;
        if (iss_valid !== '0) begin
            errors++;
            $display("FAIL %s: iss_valid actual %b expected 0", req, iss_valid);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // monitor: compares issue ports against the scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            for (int s = 0; s < F; s++) begin
                if (iss_valid[s]) begin
                    checks++;
                    if (sb.size() == 0) begin
                        errors++;
                        $display("FAIL R2/R5: unexpected issue slot %0d dst %0d cycle %0d, expected none",
                                 s, iss_dst[s*TW +: TW], cyc);
                    end else begin
                        mon_e = sb.pop_front();
                        if (mon_e.cyc != cyc || mon_e.slot != s ||
                            mon_e.dst != int'(iss_dst[s*TW +: TW])) begin
                            errors++;
                            $display("FAIL %s: issue actual cyc %0d slot %0d dst %0d expected cyc %0d slot %0d dst %0d",
                                     mon_e.req, cyc, s, iss_dst[s*TW +: TW],
                                     mon_e.cyc, mon_e.slot, mon_e.dst);
                        end
                    end
                end
            end
            while (sb.size() > 0 && sb[0].cyc < cyc) begin
                mon_e = sb.pop_front();
                checks++;
                errors++;
                $display("FAIL %s: missing issue dst %0d, actual none expected at cyc %0d slot %0d",
                         mon_e.req, mon_e.dst, mon_e.cyc, mon_e.slot);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        clr();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check_ok(1'b1, "R1");
        checks++;
        if (iss_valid !== '0) begin
            errors++;
            $display("FAIL R1: iss_valid actual %b expected 0", iss_valid);
        end
        tick();

        // R3 / R8: two ready instructions, lane 0 older
        put(0, 1, 1, 2, 1, 10);
        put(1, 3, 1, 4, 1, 11);
        expect_iss(cyc + 1, 0, 10, "R3");
        expect_iss(cyc + 1, 1, 11, "R8");
        tick(); tick();

        // R7: older waiting, younger ready issues around it
        put(0, 40, 0, 7, 1, 5);
        put(1, 8, 1, 9, 1, 6);
        expect_iss(cyc + 1, 0, 6, "R7");
        tick(); tick(); tick();
        bcast(0, 40);
        expect_iss(cyc + 1, 0, 5, "R4");
        tick(); tick();

        // R5: other producers and invalid broadcasts do not wake
        put(0, 33, 0, 2, 1, 7);
        tick();
        bcast(0, 34); bcast(1, 35);
        tick();
        check_idle("R5");
        bc_tag[0 +: TW] = TW'(33);
        tick();
        check_idle("R5");
        bcast(1, 33);
        expect_iss(cyc + 1, 0, 7, "R4");
        tick(); tick();

        // R6: broadcast in the dispatch cycle
        put(0, 50, 0, 51, 1, 41);
        bcast(0, 50);
        expect_iss(cyc + 1, 0, 41, "R6");
        tick(); tick();

        // R4: sources woken in different cycles
        put(0, 52, 0, 53, 0, 42);
        tick();
        bcast(0, 52);
        tick();
        check_idle("R4");
        bcast(1, 53);
        expect_iss(cyc + 1, 0, 42, "R4");
        tick(); tick();

        // R4: both sources woken together on two ports
        put(0, 54, 0, 55, 0, 43);
        tick();
        bcast(0, 55); bcast(1, 54);
        expect_iss(cyc + 1, 0, 43, "R4");
        tick(); tick();

        // R8 / R9: age order independent of slot position
        put(0, 61, 0, 1, 1, 11);
        put(1, 61, 0, 1, 1, 12);
        tick();
        put(0, 60, 0, 1, 1, 13);
        put(1, 60, 0, 1, 1, 14);
        bcast(0, 61);
        expect_iss(cyc + 1, 0, 11, "R8");
        expect_iss(cyc + 1, 1, 12, "R10");
        tick();
        tick();
        put(0, 60, 0, 1, 1, 15);
        put(1, 60, 0, 1, 1, 16);
        tick();
        bcast(1, 60);
        expect_iss(cyc + 1, 0, 13, "R8");
        expect_iss(cyc + 1, 1, 14, "R8");
        expect_iss(cyc + 2, 0, 15, "R9");
        expect_iss(cyc + 2, 1, 16, "R9");
        tick(); tick(); tick();

        // R2: fill seven slots, refuse two lanes, accept one
        for (int k = 0; k < 3; k++) begin
            put(0, 70, 0, 1, 1, 20 + 2*k);
            put(1, 70, 0, 1, 1, 21 + 2*k);
            tick();
        end
        put(0, 70, 0, 1, 1, 26);
        tick();
        put(0, 1, 1, 1, 1, 28);
        put(1, 1, 1, 1, 1, 29);
        check_ok(1'b0, "R2");
        tick();
        put(1, 1, 1, 1, 1, 30);
        check_ok(1'b1, "R2");
        expect_iss(cyc + 1, 0, 30, "R2");
        tick();
        put(0, 1, 1, 1, 1, 31);
        check_ok(1'b0, "R2");
        bcast(0, 70);
        expect_iss(cyc + 1, 0, 20, "R8");
        expect_iss(cyc + 1, 1, 21, "R8");
        expect_iss(cyc + 2, 0, 22, "R8");
        expect_iss(cyc + 2, 1, 23, "R8");
        expect_iss(cyc + 3, 0, 24, "R8");
        expect_iss(cyc + 3, 1, 25, "R8");
        expect_iss(cyc + 4, 0, 26, "R10");
        repeat (7) tick();

        while (sb.size() > 0) begin
            mon_e = sb.pop_front();
            checks++;
            errors++;
            $display("FAIL %s: missing issue dst %0d, actual none expected at cyc %0d",
                     mon_e.req, mon_e.dst, mon_e.cyc);
        end
        summary();
        $finish;
    end

endmodule